// File: doc/BRIEF.md
# Boot ROM Slave with Low-Address Remap

This block is an AHB slave holding a 16 KB read-only boot store. It does its own address decode. The store answers in a 64 KB window at its normal base, 0x8009_0000, and repeats every 16 KB inside that window. When the internal-boot strap is high at reset, the same store also answers in the 64 KB window at address zero, so the processor can fetch its first instructions there. Software turns that low alias off by writing a one to bit 0 of a control word. From then on only the normal window answers, until the next reset.

Every read of the store or of the control word takes one wait state. Writes, IDLE and BUSY transfers, and transfers that miss every window finish with no wait state. The response is always OKAY.

A four-state machine tracks the data phase:
- `ST_IDLE` means no data phase is in progress, or the data phase needs no wait.
- `ST_RWAIT` is the wait cycle of a read.
- `ST_RDATA` is the cycle in which read data is delivered.
- `ST_WDATA` is the data phase of a write.

Its transitions are:
- From `ST_IDLE`, `ST_RDATA` or `ST_WDATA`, a decoded read goes to `ST_RWAIT`.
- From the same three states, a decoded write goes to `ST_WDATA`.
- From the same three states, anything else goes to `ST_IDLE`.
- `ST_RWAIT` always goes to `ST_RDATA`.

Top module: `boot_rom_ahb`

## Requirements
- R1: While reset is low and right after it, hreadyout is 1, hresp is 0 and hrdata is 0. The remap flag takes the value of boot_internal.
- R2: A NONSEQ or SEQ read that hits a window holds hreadyout low for exactly the cycle after the address phase. The data appears on hrdata in the following cycle, with hreadyout high.
- R3: The store word at byte offset o, with word index i = o[13:2], reads as {4'hB, i, ~i, 4'h5}.
- R4: Within the normal window (haddr[31:16] = 16'h8009), bits 15:14 are ignored. Offsets 16 KB apart return the same word.
- R5: When the remap flag is 1, reads with haddr[31:16] = 0 return the store word for haddr[13:2]. When the flag is 0, such reads finish with no wait and hrdata 0.
- R6: The control word is at 0x800A_0000. A write with hwdata[0] = 1 clears the remap flag. A write with hwdata[0] = 0 leaves it unchanged. A read returns the flag in bit 0 and zeros above. Once cleared, the flag stays cleared until reset.
- R7: A transfer whose address phase coincides with the clearing write's data phase is decoded with the old mapping. The transfer after it uses the new mapping.
- R8: A write to either store window finishes with no wait and OKAY. It does not change later reads.
- R9: IDLE (htrans 2'b00) and BUSY (2'b01) transfers finish with no wait and OKAY. hresp is 0 at all times.
- R10: A read that hits no window finishes with no wait and hrdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| boot_internal | input | 1 | Boot strap; 1 maps the store at zero at reset |
| haddr | input | 32 | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for a write transfer |
| hwdata | input | 32 | Write data, in the data phase |
| hready | input | 1 | Bus ready; 1 means the address phase is taken |
| hreadyout | output | 1 | Slave ready for the current data phase |
| hresp | output | 1 | Transfer response, always OKAY (0) |
| hrdata | output | 32 | Read data |

## Verification
The properties assume that hready is this slave's own hreadyout looped back, so the only stalled cycles are the slave's own waits. They also assume that the strap is stable while reset is released. The bench ties hready to hreadyout, changes boot_internal only while hresetn is low, and drives an address phase only on cycles where the returned ready is high. It never presents a transfer during a wait cycle. Write data is driven in the cycle after a write's address phase, as the pipelined bus requires.

// File: rtl/boot_rom_pkg.sv
package boot_rom_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RWAIT = 2'd1,
        ST_RDATA = 2'd2,
        ST_WDATA = 2'd3
    } bus_state_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_CTRL = 2'd2
    } target_e;

    // Store contents, computed per word index
    function automatic logic [31:0] rom_word(input logic [11:0] idx);
        return {4'hB, idx, ~idx, 4'h5};
    endfunction

endpackage

// File: rtl/boot_rom_decode.sv
module boot_rom_decode
    import boot_rom_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h8009_0000,
    parameter int          WIN_BITS  = 16,
    parameter logic [31:0] CTRL_ADDR = 32'h800A_0000
) (
    input  logic [31:0] addr,
    input  logic        remap,
    output target_e     tgt
);

    always_comb begin
        if (addr[31:2] == CTRL_ADDR[31:2]) begin
            tgt = TGT_CTRL;
        end else if (addr[31:WIN_BITS] == BASE_ADDR[31:WIN_BITS]) begin
            tgt = TGT_ROM;
        end else if (remap && (addr[31:WIN_BITS] == '0)) begin
            tgt = TGT_ROM;
        end else begin
            tgt = TGT_NONE;
        end
    end

endmodule

// File: rtl/boot_rom_array.sv
module boot_rom_array
    import boot_rom_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [31:0]      q
);

    always_ff @(posedge clk) begin
        if (en) begin
            q <= rom_word(12'(idx));
        end
    end

endmodule

// File: rtl/boot_rom_remap.sv
module boot_rom_remap (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    input  logic clr,
    output logic remap
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remap <= strap;
        end else if (clr) begin
            remap <= 1'b0;
        end
    end

endmodule

// File: rtl/boot_rom_ahb.sv
module boot_rom_ahb
    import boot_rom_pkg::*;
#(
    parameter int          ROM_BYTES = 16384,
    parameter logic [31:0] BASE_ADDR = 32'h8009_0000,
    parameter int          WIN_BITS  = 16,
    parameter logic [31:0] CTRL_ADDR = 32'h800A_0000
) (
    input  logic        hclk,
    input  logic        hresetn,
    input  logic        boot_internal,
    input  logic [31:0] haddr,
    input  logic [1:0]  htrans,
    input  logic        hwrite,
    input  logic [31:0] hwdata,
    input  logic        hready,
    output logic        hreadyout,
    output logic        hresp,
    output logic [31:0] hrdata
);

    localparam int ROM_AW = $clog2(ROM_BYTES);
    localparam int IDX_W  = ROM_AW - 2;

    bus_state_e       state_q, state_d;
    target_e          tgt;
    logic             remap;
    logic             clr;
    logic             rom_en;
    logic [31:0]      rom_q;
    logic [IDX_W-1:0] idx_q;
    logic             ctrl_q;
    logic             wctrl_q;
    logic             ctrl_val_q;
    logic             addr_ph;
    logic             unused_bits;

    assign unused_bits = ^{hwdata[31:1], haddr[1:0], htrans[0]};
    assign addr_ph     = hready && htrans[1];

    boot_rom_decode #(
        .BASE_ADDR(BASE_ADDR),
        .WIN_BITS (WIN_BITS),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_decode (
        .addr (haddr),
        .remap(remap),
        .tgt  (tgt)
    );

    boot_rom_remap u_remap (
        .clk  (hclk),
        .rst_n(hresetn),
        .strap(boot_internal),
        .clr  (clr),
        .remap(remap)
    );

    boot_rom_array #(.IDX_W(IDX_W)) u_array (
        .clk(hclk),
        .en (rom_en),
        .idx(idx_q),
        .q  (rom_q)
    );

    // State register
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Address-phase capture
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            idx_q      <= '0;
            ctrl_q     <= 1'b0;
            wctrl_q    <= 1'b0;
            ctrl_val_q <= 1'b0;
        end else begin
            if (addr_ph) begin
                idx_q   <= haddr[ROM_AW-1:2];
                ctrl_q  <= (tgt == TGT_CTRL);
                wctrl_q <= hwrite && (tgt == TGT_CTRL);
            end
            if (state_q == ST_RWAIT) begin
                ctrl_val_q <= remap;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_RWAIT: state_d = ST_RDATA;
            ST_IDLE, ST_RDATA, ST_WDATA: begin
                if (addr_ph && (tgt != TGT_NONE)) begin
                    state_d = hwrite ? ST_WDATA : ST_RWAIT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        hreadyout = 1'b1;
        hresp     = 1'b0;
        hrdata    = '0;
        clr       = 1'b0;
        rom_en    = 1'b0;
        unique case (state_q)
            ST_RWAIT: begin
                hreadyout = 1'b0;
                rom_en    = !ctrl_q;
            end
            ST_RDATA: hrdata = ctrl_q ? {31'b0, ctrl_val_q} : rom_q;
            ST_WDATA: clr = wctrl_q && hwdata[0];
            default: ;
        endcase
    end

endmodule

// File: rtl/boot_rom_chk.sv
module boot_rom_chk #(
    parameter logic [15:0] BASE_HI = 16'h8009
) (
    input logic        hclk,
    input logic        hresetn,
    input logic        hready,
    input logic [1:0]  htrans,
    input logic        hwrite,
    input logic [31:0] haddr,
    input logic        hreadyout,
    input logic        remap
);

    logic unused_chk;
    assign unused_chk = ^{htrans[0], haddr[15:0]};

    // R2
    rd_wait_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hready && htrans[1] && !hwrite && haddr[31:16] == BASE_HI) |=> !hreadyout);

    // R2
    one_wait_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        !hreadyout |=> hreadyout);

    // R9
    idle_zero_wait_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hready && !htrans[1]) |=> hreadyout);

    // R8
    wr_zero_wait_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hready && htrans[1] && hwrite) |=> hreadyout);

    // R10
    miss_zero_wait_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hready && htrans[1] && haddr[31:16] == 16'h4000) |=> hreadyout);

    // R6
    remap_sticky_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        !$rose(remap));

endmodule

bind boot_rom_ahb boot_rom_chk u_chk (
    .hclk     (hclk),
    .hresetn  (hresetn),
    .hready   (hready),
    .htrans   (htrans),
    .hwrite   (hwrite),
    .haddr    (haddr),
    .hreadyout(hreadyout),
    .remap    (remap)
);

// File: tb/test_boot_rom_ahb.sv
module test_boot_rom_ahb;

    logic        hclk = 1'b0;
    logic        hresetn;
    logic        boot_internal;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [31:0] hwdata;
    logic        hready;
    logic        hreadyout;
    logic        hresp;
    logic [31:0] hrdata;

    always #4 hclk = ~hclk;
    assign hready = hreadyout;

    boot_rom_ahb i_boot_rom_ahb (
        .hclk(hclk), .hresetn(hresetn), .boot_internal(boot_internal),
        .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hwdata(hwdata),
        .hready(hready), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata)
    );

    localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;
    localparam logic [31:0] CTRL = 32'h800A_0000;

    int    checks = 0;
    int    bad    = 0;
    string tag    = "R1";

    // Reference model state: 0 none, 1 read wait, 2 read data, 3 ctrl write, 4 store write
    int          mkind  = 0;
    bit          mremap = 1'b0;
    bit          mctrl  = 1'b0;
    logic [31:0] maddr  = '0;
    logic [31:0] mval   = '0;

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        logic [11:0] i;
        i = a[13:2];
        return {4'hB, i, ~i, 4'h5};
    endfunction

    function automatic int hit(input logic [31:0] a, input bit rm);
        if (a[31:2] == CTRL[31:2]) return 2;
        if (a[31:16] == 16'h8009) return 1;
        if (rm && a[31:16] == 16'h0000) return 1;
        return 0;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic [31:0] a, input logic [1:0] t, input bit w, input logic [31:0] d);
        bit old_rm;
        int h;
        haddr = a; htrans = t; hwrite = w; hwdata = d;
        @(posedge hclk);
        old_rm = mremap;
        if (mkind == 1) begin
            mkind = 2;
            mval  = mctrl ? {31'b0, old_rm} : exp_word(maddr);
        end else begin
            if (mkind == 3 && d[0]) mremap = 1'b0;
            if (t[1]) begin
                h = hit(a, old_rm);
                mctrl = (h == 2);
                maddr = a;
                if (h == 0)      mkind = 0;
                else if (!w)     mkind = 1;
                else if (h == 2) mkind = 3;
                else             mkind = 4;
            end else begin
                mkind = 0;
            end
        end
        @(negedge hclk);
        check(tag, "hreadyout", {31'b0, hreadyout}, {31'b0, mkind != 1});
        check(tag, "hrdata", hrdata, (mkind == 2) ? mval : 32'h0);
        check(tag, "hresp", {31'b0, hresp}, 32'h0);
    endtask

    task automatic rd(input logic [31:0] a);
        cyc(a, T_NSEQ, 1'b0, 32'h0);
        cyc(32'h0, T_IDLE, 1'b0, 32'h0);
        cyc(32'h0, T_IDLE, 1'b0, 32'h0);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        cyc(a, T_NSEQ, 1'b1, 32'h0);
        cyc(32'h0, T_IDLE, 1'b0, d);
    endtask

    task automatic do_reset(input bit strap);
        hresetn = 1'b0; boot_internal = strap;
        haddr = '0; htrans = T_IDLE; hwrite = 1'b0; hwdata = '0;
        repeat (3) @(posedge hclk);
        @(negedge hclk);
        check("R1", "reset hreadyout", {31'b0, hreadyout}, 32'h1);
        check("R1", "reset hrdata", hrdata, 32'h0);
        check("R1", "reset hresp", {31'b0, hresp}, 32'h0);
        hresetn = 1'b1;
        mkind = 0; mremap = strap;
    endtask

    initial begin
        repeat (100000) @(posedge hclk);
        bad++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        tag = "R1"; rd(CTRL);
        tag = "R2"; rd(32'h8009_0000); rd(32'h8009_0104);
        // back-to-back: NONSEQ then SEQ during the data cycle
        cyc(32'h8009_0200, T_NSEQ, 1'b0, 0);
        cyc(32'h0, T_IDLE, 1'b0, 0);
        cyc(32'h8009_0204, T_SEQ, 1'b0, 0);
        cyc(32'h0, T_IDLE, 1'b0, 0);
        cyc(32'h0, T_IDLE, 1'b0, 0);
        tag = "R3"; rd(32'h8009_3FFC); rd(32'h8009_2AA8);
        tag = "R4"; rd(32'h8009_4104); rd(32'h8009_C3FC); rd(32'h8009_8000);
        tag = "R5"; rd(32'h0000_0010); rd(32'h0000_7FFC);
        tag = "R9";
        cyc(32'h8009_0000, T_IDLE, 1'b0, 0);
        cyc(32'h8009_0004, T_BUSY, 1'b0, 0);
        cyc(32'h0000_0000, T_BUSY, 1'b1, 0);
        tag = "R8"; wr(32'h8009_0040, 32'hFFFF_FFFF); wr(32'h0000_0040, 32'h1234_5678);
        rd(32'h8009_0040);
        tag = "R10"; rd(32'h4000_0000); rd(32'h8008_0000);
        tag = "R6"; wr(CTRL, 32'hFFFF_FFFE); rd(CTRL); rd(32'h0000_0020);
        // R7: read at zero issued in the clearing write's data phase
        tag = "R7";
        cyc(CTRL, T_NSEQ, 1'b1, 0);
        cyc(32'h0000_0020, T_NSEQ, 1'b0, 32'h1);
        cyc(32'h0, T_IDLE, 1'b0, 0);
        cyc(32'h0, T_IDLE, 1'b0, 0);
        rd(32'h0000_0020);
        tag = "R6"; rd(CTRL); wr(CTRL, 32'h1); rd(CTRL); rd(32'h8009_0020);
        do_reset(1'b0);
        tag = "R5"; rd(32'h0000_0010); rd(CTRL); rd(32'h8009_0010);
        do_reset(1'b1);
        tag = "R1"; rd(CTRL); rd(32'h0000_0008);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule